// File: doc/BRIEF.md
# Eight-Output Addressable Latch

A single data bit is steered by a binary index into one of eight storage bits. An active-low write strobe opens the indexed bit. While the strobe stays low, that bit tracks the data input, and it keeps the last value once the strobe rises. Every other bit keeps its contents. A shared active-low clear input zeroes the bank. If clear and the write strobe are both low, the bank acts as a 1-of-8 demultiplexer: the indexed output carries the data bit and all the others read 0.

This version uses a clock. The strobe, clear, data and index are sampled on every rising clock edge, and the outputs show the result one edge later. While the strobe is low, the indexed bit is rewritten on every cycle. The value kept is therefore the sample from the last edge at which the strobe was still low. The index width is a parameter, and the bank holds 2**ADDR_W bits. The block resets asynchronously and leaves reset on a clock edge.

Top module: `bit_steer_latch`

## Requirements
- R1: While `rst_n` is low, every bit of `q` reads 0. Once `rst_n` is released, `q` stays 0 until the first write or demultiplex cycle.
- R2: `addr` is an unsigned binary index with bit 0 as the least significant bit. It selects output `q[addr]`, and a write changes no other output bit.
- R3: On a clock edge where `en_n` = 0 and `clr_n` = 1, `q[addr]` takes the sampled `din`. Holding `en_n` low makes that bit follow `din` cycle by cycle.
- R4: After `en_n` goes high, the indexed bit keeps the `din` sampled at the last edge where `en_n` was still low. The `din` value present at the edge where `en_n` is first seen high has no effect.
- R5: During a write with `clr_n` = 1, every output bit that is not indexed keeps its previous value.
- R6: With `en_n` = 1 and `clr_n` = 1, `q` keeps its value whatever `din` and `addr` do.
- R7: With `clr_n` = 0 and `en_n` = 1, all of `q` reads 0 after the edge. It stays 0 for as long as that condition holds.
- R8: With `clr_n` = 0 and `en_n` = 0, `q` equals `din` shifted left by `addr`: the indexed bit is `din` and all other bits are 0.
- R9: Inputs sampled at a rising clock edge show on `q` right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| din | input | 1 | Serial data bit to store |
| addr | input | ADDR_W | Binary index of the target bit, bit 0 least significant |
| en_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low clear for the whole bank |
| q | output | 2**ADDR_W | Stored bits |

## Verification
The bench builds the block with ADDR_W = 3, which gives the full eight-bit bank, and with a two-stage reset synchronizer. At that size the bench sweeps every index, both data values and all four strobe/clear combinations, starting from several preloaded patterns. The whole space runs in a few hundred cycles, and a reference array is compared against every output bit after each edge. Directed sequences cover the timing cases: tracking while the strobe is held low, what is kept when the strobe rises, the one-edge latency, and a reset asserted in the middle of a run.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  // Operating mode of the bank, decoded from the two active-low controls.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_DEMUX = 2'd3
  } bsl_mode_e;

endpackage

// File: rtl/bsl_rst_sync.sv
module bsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] shift_q;
  logic [LAST:0] shift_d;

  always_comb begin
    shift_d = {shift_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[LAST];

endmodule

// File: rtl/bsl_mode_dec.sv
module bsl_mode_dec
  import bsl_pkg::*;
(
  input  logic      en_n,
  input  logic      clr_n,
  output bsl_mode_e mode
);

  always_comb begin
    unique case ({~clr_n, ~en_n})
      2'b00:   mode = MODE_HOLD;
      2'b01:   mode = MODE_WRITE;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_DEMUX;
    endcase
  end

endmodule

// File: rtl/bsl_addr_dec.sv
module bsl_addr_dec #(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic [(1<<ADDR_W)-1:0]  sel
);

  localparam int NBITS = 1 << ADDR_W;

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    assign sel[i] = (addr == IDX);
  end

endmodule

// File: rtl/bsl_bit_cell.sv
module bsl_bit_cell
  import bsl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  input  logic      sel,
  input  bsl_mode_e mode,
  output logic      q
);

  logic q_r;
  logic q_nxt;
  logic ce;

  // next-state and clock enable
  always_comb begin
    ce    = 1'b0;
    q_nxt = q_r;
    unique case (mode)
      MODE_HOLD: begin
        ce    = 1'b0;
        q_nxt = q_r;
      end
      MODE_WRITE: begin
        ce    = sel;
        q_nxt = din;
      end
      MODE_CLEAR: begin
        ce    = 1'b1;
        q_nxt = 1'b0;
      end
      default: begin
        ce    = 1'b1;
        q_nxt = sel & din;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= 1'b0;
    else if (ce) q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/bit_steer_latch.sv
module bit_steer_latch
  import bsl_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int RST_STAGE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     din,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     en_n,
  input  logic                     clr_n,
  output logic [(1<<ADDR_W)-1:0]   q
);

  localparam int NBITS = 1 << ADDR_W;

  logic             rst_int_n;
  bsl_mode_e        mode;
  logic [NBITS-1:0] sel;
  logic [NBITS-1:0] bits;

  bsl_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bsl_mode_dec u_mode_dec (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  bsl_addr_dec #(.ADDR_W(ADDR_W)) u_addr_dec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    bsl_bit_cell u_cell (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (din),
      .sel   (sel[i]),
      .mode  (mode),
      .q     (bits[i])
    );
  end

  assign q = bits;

  // R3
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_WRITE) |=> ((q & $past(sel)) == ($past(din) ? $past(sel) : '0)));

  // R5
  others_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_WRITE) |=> ((q & ~$past(sel)) == ($past(q) & ~$past(sel))));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_HOLD) |=> $stable(q));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_CLEAR) |=> (q == '0));

  // R8
  demux_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == MODE_DEMUX) |=> ((q & ~$past(sel)) == '0));

  // R2
  single_change_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_n |=> ($countones(q ^ $past(q)) <= 1));

endmodule

// File: tb/bit_steer_latch_tb.sv
`timescale 1ns/1ps
module bit_steer_latch_tb;

  localparam int AW = 3;
  localparam int NB = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          din;
  logic [AW-1:0] addr;
  logic          en_n;
  logic          clr_n;
  logic [NB-1:0] q;

  logic [NB-1:0] ref_q;
  int checks;
  int errors;

  bit_steer_latch #(.ADDR_W(AW), .RST_STAGE(2)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .addr  (addr),
    .en_n  (en_n),
    .clr_n (clr_n),
    .q     (q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [NB-1:0] exp, input string tag);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q=%h expected=%h", tag, q, exp);
    end
  endtask

  task automatic step(input logic d, input logic [AW-1:0] a,
                      input logic e_n, input logic c_n, input string tag);
    @(negedge clk);
    din = d; addr = a; en_n = e_n; clr_n = c_n;
    @(posedge clk);
    #1;
    if (!e_n) begin
      if (!c_n) ref_q = '0;
      ref_q[a] = d;
    end else if (!c_n) begin
      ref_q = '0;
    end
    check(ref_q, tag);
  endtask

  function automatic string tag_for(input logic e_n, input logic c_n);
    if (!e_n && c_n)  return "R3/R5 write";
    if (e_n && c_n)   return "R6 hold";
    if (e_n && !c_n)  return "R7 clear";
    return "R8 demux";
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog q=%h expected=done", q);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NB-1:0] pat [4];
    checks = 0; errors = 0;
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h00;
    rst_n = 1'b0; din = 1'b1; addr = '0; en_n = 1'b0; clr_n = 1'b1;
    ref_q = '0;
    repeat (3) @(posedge clk);
    #1;
    check('0, "R1 reset held");
    @(negedge clk);
    en_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check('0, "R1 after release");

    // R9: no change before the sampling edge, change right after it
    @(negedge clk);
    din = 1'b1; addr = 3'd6; en_n = 1'b0; clr_n = 1'b1;
    @(negedge clk);
    @(posedge clk);
    #0.5;
    checks++;
    if (q[6] !== 1'b1) begin
      errors++;
      $display("FAIL R9 q=%h expected bit6 set", q);
    end
    en_n = 1'b1;
    ref_q = 8'h40;
    @(negedge clk);
    check(ref_q, "R9 latched");
    din = 1'b0; addr = 3'd1; en_n = 1'b0;
    #1.5;
    check(ref_q, "R9 before edge");
    @(posedge clk);
    #1;
    ref_q[1] = 1'b0;
    check(ref_q, "R9 after edge");
    step(1'b0, 3'd1, 1'b1, 1'b1, "R6 hold");

    // sweeps from several preloaded patterns
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < NB; b++)
        step(pat[p][b], AW'(b), 1'b0, 1'b1, "R2/R5 preload");
      check(pat[p], "R2 pattern");
      for (int a = 0; a < NB; a++) begin
        for (int d = 0; d < 2; d++) begin
          for (int m = 0; m < 4; m++) begin
            logic e_n, c_n;
            e_n = m[0]; c_n = ~m[1];
            step(d[0], AW'(a), e_n, c_n, tag_for(e_n, c_n));
            if (!c_n && !e_n) check(NB'(d[0]) << a, "R8 shift");
          end
          step(1'b1, AW'(a), 1'b0, 1'b1, "R3 refill");
        end
      end
    end

    // R7: clear held for several cycles while data and index move
    for (int k = 0; k < 6; k++) step(k[0], AW'(k), 1'b1, 1'b0, "R7 held");

    // R3 transparency then R4 retention
    step(1'b1, 3'd5, 1'b1, 1'b1, "R6 setup");
    step(1'b1, 3'd5, 1'b0, 1'b1, "R3 track");
    step(1'b0, 3'd5, 1'b0, 1'b1, "R3 track");
    step(1'b1, 3'd5, 1'b0, 1'b1, "R3 track");
    step(1'b0, 3'd5, 1'b0, 1'b1, "R3 track");
    step(1'b1, 3'd5, 1'b1, 1'b1, "R4 rise");
    checks++;
    if (q[5] !== 1'b0) begin
      errors++;
      $display("FAIL R4 q5=%b expected=0", q[5]);
    end

    // R6: strobe high, data and index wander
    for (int k = 0; k < 16; k++) step(k[1], AW'(k * 3), 1'b1, 1'b1, "R6 wander");

    // R1: reset asserted mid-run
    step(1'b1, 3'd2, 1'b0, 1'b1, "R3 write");
    @(negedge clk);
    en_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check('0, "R1 mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    ref_q = '0;
    check('0, "R1 recovered");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule